// File: doc/BRIEF.md
# Banked GPIO Interrupt Aggregator

This block gathers pin events from a parameterised number of GPIO pins (at most 144) into per-set interrupt status registers. Each set covers 32 pins. It then folds those registers into level-sensitive interrupt lines, one for each group of 16 pins. A single shared register bus reaches every status register and one global enable register. That register holds one bit per 16-pin interrupt bank. Software enables the banks it cares about, services a raised line by reading the matching status register, and clears the bits it has handled by writing ones to them.

Every 32-pin set is split into two interrupt banks. Bank `n` takes its status from set `n/2`: even banks use bits 15:0 and odd banks use bits 31:16. A bank line stays high for as long as its enable bit is set and its 16-bit slice holds any set bit. Pins, bits and banks beyond the configured pin count are never built. They read as zero and never interrupt.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After synchronous reset, the enable register and all status registers are 0, every `bank_irq` bit is 0 and `bus_rdata` is 0.
- R2: The bank-enable register sits at byte offset 0x08 and can be written and read back. Bit n of it enables bank n. Bits at or above the bank count are discarded on write and read as 0.
- R3: The status register of set s sits at byte offset 0x10 + 0x28*s + 0x24, so set 0 is at 0x34 and set 4 at 0xD4. A one-cycle pulse on `pin_event[p]` sets bit p%32 of set p/32 at the clock edge that samples the pulse.
- R4: Writing to a status register clears every bit that is 1 in the write data. Bits written as 0 keep their value, and nothing else clears a status bit.
- R5: If a pin event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: `bank_irq[n]` is 1 exactly when enable bit n is 1 and bits 16*(n%2)+15 down to 16*(n%2) of set n/2 are not all zero. It follows the register state in the cycle right after the edge that changed it.
- R7: Status bits for pin indices at or above NUM_PINS never set and always read 0. With 144 pins, set 4 reads at most 0x0000FFFF, and there is no tenth bank line.
- R8: Any address other than the enable and status offsets, including any address that is not word-aligned, reads as 0. A write to such an address changes no register.
- R9: A read presents its data on `bus_rdata` in the cycle after the request, holding the state from before that edge. `bus_rdata` is 0 in every cycle that follows a non-read cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request, valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_event | input | NUM_PINS | One-cycle event pulses, one per pin |
| bank_irq | output | (NUM_PINS+15)/16 | Level interrupt, one per 16-pin bank |

## Verification
Two functions can land on a status bit in the same cycle: a new pin event setting the bit, and a software write clearing it. The bench provokes this by pulsing a pin in the same cycle that it writes all ones to that pin's status register. It expects the event bit to survive while every other bit is cleared. The bench also lets a read coincide with an event on the register being read. It expects the old value on the bus and the new value on the next read. Every byte address is swept for both reads and ignored writes against an arithmetic model of the register offsets.

// File: rtl/gpio_agg_pkg.sv
package gpio_agg_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int SET_PINS   = 32;
    localparam int BANK_PINS  = 16;
    localparam int MAX_SETS   = 5;

    // Fixed byte offsets; software and the bank decode rely on them
    localparam int EN_OFFSET   = 'h08;
    localparam int SET_BASE    = 'h10;
    localparam int SET_STRIDE  = 'h28;
    localparam int STAT_OFFSET = 'h24;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    typedef struct packed {
        logic                hit_en;
        logic [MAX_SETS-1:0] hit_set;
    } dec_t;

    function automatic logic [ADDR_W-1:0] stat_addr(input int s);
        return ADDR_W'(SET_BASE + SET_STRIDE * s + STAT_OFFSET);
    endfunction

    function automatic logic [DATA_W-1:0] used_mask(input int used);
        return DATA_W'((64'd1 << used) - 64'd1);
    endfunction

endpackage

// File: rtl/gpio_agg_decode.sv
module gpio_agg_decode
    import gpio_agg_pkg::*;
#(
    parameter int NUM_SETS = 5
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_e              acc,
    output dec_t              dec
);

    always_comb begin
        acc = ACC_IDLE;
        if (bus_en) begin
            acc = bus_we ? ACC_WRITE : ACC_READ;
        end
        dec        = '0;
        dec.hit_en = (bus_addr == ADDR_W'(EN_OFFSET));
        for (int s = 0; s < NUM_SETS; s++) begin
            dec.hit_set[s] = (bus_addr == stat_addr(s));
        end
    end

endmodule

// File: rtl/gpio_stat_set.sv
module gpio_stat_set
    import gpio_agg_pkg::*;
#(
    parameter int USED_PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] stat
);

    localparam logic [DATA_W-1:0] MASK = used_mask(USED_PINS);

    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] clr_bits;

    assign clr_bits = clr_we ? clr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            // a fresh event outranks a simultaneous clear
            stat_q <= ((stat_q & ~clr_bits) | evt) & MASK;
        end
    end

    assign stat = stat_q;

    for (genvar i = 0; i < USED_PINS; i++) begin : g_chk
        AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> stat[i]) else $error("event lost bit %0d", i); // R5
        AST_HOLD_UNLESS_CLEARED: assert property (@(posedge clk) disable iff (rst)
            (stat[i] && !(clr_we && clr_data[i])) |=> stat[i])
            else $error("bit %0d dropped without clear", i); // R4
    end

endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate
    import gpio_agg_pkg::*;
#(
    parameter int NUM_SETS  = 5,
    parameter int NUM_BANKS = 9
) (
    input  logic [NUM_SETS*SET_PINS-1:0] stat_flat,
    input  logic [NUM_BANKS-1:0]         bank_en,
    output logic [NUM_BANKS-1:0]         bank_irq
);

    // bank n maps to set n/2, half n%2: flat index n*16
    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
        assign bank_irq[n] = bank_en[n] & (|stat_flat[n*BANK_PINS +: BANK_PINS]);
    end

endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
    import gpio_agg_pkg::*;
#(
    parameter int NUM_PINS = 144
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             bus_en,
    input  logic                             bus_we,
    input  logic [7:0]                       bus_addr,
    input  logic [31:0]                      bus_wdata,
    output logic [31:0]                      bus_rdata,
    input  logic [NUM_PINS-1:0]              pin_event,
    output logic [(NUM_PINS+15)/16-1:0]      bank_irq
);

    localparam int NUM_SETS  = (NUM_PINS + SET_PINS - 1) / SET_PINS;
    localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
    localparam int FLAT_W    = NUM_SETS * SET_PINS;

    acc_e                 acc;
    dec_t                 dec;
    logic [NUM_BANKS-1:0] en_q;
    logic [FLAT_W-1:0]    evt_flat;
    logic [FLAT_W-1:0]    stat_flat;
    logic [DATA_W-1:0]    rd_mux;
    logic [DATA_W-1:0]    rdata_q;

    assign evt_flat = FLAT_W'(pin_event);

    gpio_agg_decode #(.NUM_SETS(NUM_SETS)) u_decode (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .acc      (acc),
        .dec      (dec)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        localparam int USED = (NUM_PINS - s * SET_PINS) > SET_PINS ?
                              SET_PINS : (NUM_PINS - s * SET_PINS);
        gpio_stat_set #(.USED_PINS(USED)) u_set (
            .clk      (clk),
            .rst      (rst),
            .evt      (evt_flat[s*SET_PINS +: SET_PINS]),
            .clr_we   ((acc == ACC_WRITE) && dec.hit_set[s]),
            .clr_data (bus_wdata),
            .stat     (stat_flat[s*SET_PINS +: SET_PINS])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if ((acc == ACC_WRITE) && dec.hit_en) begin
            en_q <= bus_wdata[NUM_BANKS-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        if (dec.hit_en) begin
            rd_mux = DATA_W'(en_q);
        end
        for (int s = 0; s < NUM_SETS; s++) begin
            if (dec.hit_set[s]) begin
                rd_mux = stat_flat[s*SET_PINS +: SET_PINS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= (acc == ACC_READ) ? rd_mux : '0;
        end
    end

    assign bus_rdata = rdata_q;

    gpio_bank_gate #(.NUM_SETS(NUM_SETS), .NUM_BANKS(NUM_BANKS)) u_gate (
        .stat_flat (stat_flat),
        .bank_en   (en_q),
        .bank_irq  (bank_irq)
    );

    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_READ && dec == '0) |=> bus_rdata == '0)
        else $error("unmapped read returned data"); // R8
    AST_EN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_READ && dec.hit_en) |=> (bus_rdata >> NUM_BANKS) == '0)
        else $error("enable upper bits nonzero"); // R2
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc != ACC_READ) |=> bus_rdata == '0)
        else $error("read data without read"); // R9

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_irq_chk
        AST_DISABLE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
            (acc == ACC_WRITE && dec.hit_en && !bus_wdata[n]) |=> !bank_irq[n])
            else $error("bank %0d still high after disable", n); // R6
    end

endmodule

// File: tb/gpio_irq_aggregator_bench.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_bench;

    localparam int PINS  = 144;
    localparam int SETS  = 5;
    localparam int BANKS = 9;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_en;
    logic              bus_we;
    logic [7:0]        bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [PINS-1:0]   pin_event;
    logic [BANKS-1:0]  bank_irq;

    int total = 0;
    int fails = 0;

    logic [31:0]      m_stat [SETS];
    logic [BANKS-1:0] m_en;

    always #2.5 clk = ~clk;

    gpio_irq_aggregator #(.NUM_PINS(PINS)) u_gpio_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_event (pin_event),
        .bank_irq  (bank_irq)
    );

    function automatic logic [7:0] st_addr(int s);
        return 8'(16 + 40 * s + 36);
    endfunction

    function automatic int set_of_addr(logic [7:0] a);
        for (int s = 0; s < SETS; s++) if (a == st_addr(s)) return s;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        if (a == 8'h08) return 32'(m_en);
        if (set_of_addr(a) >= 0) return m_stat[set_of_addr(a)];
        return 32'h0;
    endfunction

    function automatic logic [BANKS-1:0] model_irq();
        logic [BANKS-1:0] r;
        for (int n = 0; n < BANKS; n++)
            r[n] = m_en[n] && (m_stat[n/2][16*(n%2) +: 16] != 16'h0);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        if (a == 8'h08) m_en = d[BANKS-1:0];
        else if (set_of_addr(a) >= 0) m_stat[set_of_addr(a)] &= ~d;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [PINS-1:0] v);
        @(negedge clk);
        pin_event = v;
        @(negedge clk);
        pin_event = '0;
        for (int p = 0; p < PINS; p++) if (v[p]) m_stat[p/32][p%32] = 1'b1;
    endtask

    task automatic check_all_regs(input string tag);
        logic [31:0] d;
        bus_read(8'h08, d);
        check(d == model_read(8'h08), tag, d, model_read(8'h08));
        for (int s = 0; s < SETS; s++) begin
            bus_read(st_addr(s), d);
            check(d == m_stat[s], tag, d, m_stat[s]);
        end
        check(bank_irq == model_irq(), tag, 32'(bank_irq), 32'(model_irq()));
    endtask

    initial begin
        #1000000;
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pin_event = '0;
        m_en = '0;
        for (int s = 0; s < SETS; s++) m_stat[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        check(bank_irq == 0, "R1 irq", 32'(bank_irq), 0);
        check_all_regs("R1 regs");

        // R2 enable register width
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, d);
        check(d == 32'h1FF, "R2 enable readback", d, 32'h1FF);
        bus_write(8'h08, 32'h0000_00A5);
        bus_read(8'h08, d);
        check(d == 32'hA5, "R2 enable pattern", d, 32'hA5);

        // R3 R6 per-pin sweep with all banks enabled
        bus_write(8'h08, 32'h1FF);
        for (int p = 0; p < PINS; p++) begin
            pulse(PINS'(1) << p);
            check(bank_irq == model_irq(), "R6 irq after event", 32'(bank_irq), 32'(model_irq()));
            bus_read(st_addr(p/32), d);
            check(d == (32'h1 << (p%32)), "R3 status bit", d, 32'h1 << (p%32));
            bus_write(st_addr(p/32), 32'h1 << (p%32));
            check(bank_irq == 0, "R4 irq after clear", 32'(bank_irq), 0);
        end

        // R7 all pins at once; set 4 upper half stays zero
        pulse('1);
        bus_read(st_addr(4), d);
        check(d == 32'h0000_FFFF, "R7 set4 upper half", d, 32'h0000_FFFF);
        check(bank_irq == 9'h1FF, "R7 nine bank lines", 32'(bank_irq), 32'h1FF);

        // R6 one enable bit at a time
        for (int n = 0; n < BANKS; n++) begin
            bus_write(8'h08, 32'h1 << n);
            check(bank_irq == (9'h1 << n), "R6 single enable", 32'(bank_irq), 32'h1 << n);
        end

        // R4 zero write keeps bits, partial clear drops one bank half only
        bus_write(8'h08, 32'h1FF);
        bus_write(st_addr(1), 32'h0);
        check_all_regs("R4 zero write");
        bus_write(st_addr(1), 32'hFFFF_0000);
        check_all_regs("R4 upper half clear");
        check(bank_irq == 9'h1F7, "R6 bank3 dropped", 32'(bank_irq), 32'h1F7);

        // R8 exhaustive read sweep, then ignored writes
        for (int a = 0; a < 256; a++) begin
            bus_read(8'(a), d);
            check(d == model_read(8'(a)), "R8 read sweep", d, model_read(8'(a)));
        end
        for (int a = 0; a < 256; a++) begin
            if (a != 8 && set_of_addr(8'(a)) < 0) bus_write(8'(a), 32'hFFFF_FFFF);
        end
        check_all_regs("R8 after unmapped writes");

        // clear everything
        for (int s = 0; s < SETS; s++) bus_write(st_addr(s), 32'hFFFF_FFFF);
        check_all_regs("R4 full clear");

        // R5 event and clear in the same cycle
        bus_write(8'h08, 32'h1FF);
        pulse(PINS'(1) << 70);
        pulse(PINS'(1) << 67);
        @(negedge clk);
        pin_event = PINS'(1) << 67;
        bus_en = 1; bus_we = 1; bus_addr = st_addr(2); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_en = 0; bus_we = 0; pin_event = '0;
        m_stat[2] = 32'h1 << 3;
        bus_read(st_addr(2), d);
        check(d == 32'h8, "R5 event survives clear", d, 32'h8);
        check(bank_irq == 9'h010, "R5 irq stays", 32'(bank_irq), 32'h10);

        // R9 read returns pre-edge state; idle gives zero
        @(negedge clk);
        pin_event = PINS'(1) << 5;
        bus_en = 1; bus_we = 0; bus_addr = st_addr(0);
        @(negedge clk);
        bus_en = 0; pin_event = '0;
        check(bus_rdata == 32'h0, "R9 pre-edge value", bus_rdata, 0);
        m_stat[0][5] = 1'b1;
        @(negedge clk);
        check(bus_rdata == 32'h0, "R9 idle zero", bus_rdata, 0);
        bus_read(st_addr(0), d);
        check(d == 32'h20, "R9 new value", d, 32'h20);

        // R1 reset clears state
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        m_en = '0;
        for (int s = 0; s < SETS; s++) m_stat[s] = '0;
        check(bank_irq == 0, "R1 irq after reset", 32'(bank_irq), 0);
        check_all_regs("R1 regs after reset");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule